// File: doc/BRIEF.md
# Flash Block Erase Sequencer

This block carries out the whole erase-and-verify procedure for one flash block without software help. A one-cycle start request carries the index of the block and the first and last byte addresses of that block. The sequencer then selects the block, enables the watchdog and the programming voltage, and waits a settling time. It applies an erase pulse and then reads every byte of the block back through a simple address/strobe port, with a dummy write of the erased value before each read to latch the address. If the block is clean it releases the voltage and the selection and reports done. A bad byte starts a new, longer pulse, and the block fails with an error pulse once an attempt limit is reached.

Every wait is a parameter counted in clock cycles. The pulse width starts at an initial value and doubles after each of the first few failed attempts. It is clamped to a ceiling and then stays fixed. Programming the block to zero beforehand, the watchdog timer itself and the behaviour of the flash cells lie outside the block.

Top module: `flash_erase_seq`

## Requirements
- R1: `start` is accepted only while `busy` is low, and `busy` rises on the edge that accepts it. A `start` while busy changes no output and no latched operand.
- R2: One cycle after acceptance, exactly the `blk_sel` bit given by `blk_idx` rises. `wdog_en` rises one cycle later and `vpp_en` one cycle after that. `erase_en` rises exactly `T_ARM_SETTLE` cycles after `vpp_en` rises, and on a retry `T_ARM_SETTLE`+1 cycles after `wdog_en` rises again.
- R3: `wdog_en` is high during every erase pulse and falls on the same edge as `erase_en`.
- R4: In attempt k (counting from 1), `erase_en` stays high for exactly min(`T_PULSE_INIT`·2^min(k-1,`PULSE_DOUBLINGS`), `T_PULSE_CAP`) cycles.
- R5: `verify_en` rises the cycle after `erase_en` falls, and `erase_en` and `verify_en` are never high together.
- R6: The first `mem_wr` (with `mem_wdata` all ones) comes exactly `T_VERIFY_SETTLE` cycles after `verify_en` rises, at `mem_addr` equal to the first address. Each write is followed the next cycle by one `mem_rd` cycle at the same address, and addresses ascend by 1 up to the last address.
- R7: A byte passes only when `mem_rdata` is all ones (0xFF) in its `mem_rd` cycle. On the first byte that fails, `verify_en` falls and, below the attempt limit, a new attempt begins.
- R8: When the last byte passes, `verify_en` and `vpp_en` fall together. `blk_sel` clears exactly `T_RELEASE_SETTLE` cycles later, on the same edge that raises `done` and lowers `busy`.
- R9: A failing byte in attempt `MAX_ATTEMPTS` raises `error` for one cycle. On that same edge `vpp_en`, `verify_en`, `blk_sel` and `busy` all clear.
- R10: `done` and `error` are one-cycle pulses, never high together, and exactly one of them follows each accepted start.
- R11: During and right after reset every output is low and `mem_addr` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to erase a block |
| blk_idx | input | BLK_W | Index of the block to erase |
| blk_first | input | ADDR_W | First byte address of the block |
| blk_last | input | ADDR_W | Last byte address of the block |
| mem_rdata | input | DATA_W | Byte returned by the flash during a read cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: block erased and verified |
| error | output | 1 | One-cycle pulse: attempt limit reached |
| blk_sel | output | NUM_BLK | One-hot erase block selection |
| vpp_en | output | 1 | Programming voltage enable |
| wdog_en | output | 1 | Watchdog enable |
| erase_en | output | 1 | Erase mode bit |
| verify_en | output | 1 | Erase-verify mode bit |
| mem_addr | output | ADDR_W | Verify address |
| mem_wr | output | 1 | Dummy write strobe that latches the address |
| mem_rd | output | 1 | Read strobe |
| mem_wdata | output | DATA_W | Dummy write data, all ones during a write |

## Verification
The assertions assume that `mem_rdata` is valid in the same cycle as `mem_rd`, that `blk_first` is not above `blk_last`, and that every delay parameter is at least one cycle. The bench keeps to these rules. Its flash stub answers reads combinationally from the current address. Each byte reads back erased only after a set number of erase pulses in the current operation, and every block it requests runs upward. Extra start pulses are applied only while the block is busy, where they must be ignored.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SELECT,
    ST_WDOG,
    ST_POWER,
    ST_ARM_WAIT,
    ST_PULSE,
    ST_VERIFY_SET,
    ST_VERIFY_WAIT,
    ST_LATCH,
    ST_READ,
    ST_RELEASE
  } seq_state_t;

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned min_u(int unsigned a, int unsigned b);
    return (a < b) ? a : b;
  endfunction

  // Width for the next attempt after attempt number 'tries' failed.
  function automatic int unsigned widen_pulse(int unsigned cur, int unsigned tries,
                                              int unsigned doublings, int unsigned cap);
    if (tries > doublings) return cur;
    if (cur > cap / 2)     return cap;
    return cur * 2;
  endfunction

endpackage

// File: rtl/erase_delay_ctr.sv
module erase_delay_ctr #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          last
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign last = (cnt == CW'(1));

  // R2: a wait is armed only once the previous one has run out
  a_r2_load_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (cnt <= CW'(1)));
  // R4: every armed wait lasts at least one cycle
  a_r4_load_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (load_val != '0));
endmodule

// File: rtl/erase_attempt_ctl.sv
module erase_attempt_ctl
  import erase_seq_pkg::*;
#(
  parameter int unsigned TRY_W        = 10,
  parameter int unsigned PW_W         = 24,
  parameter int unsigned PULSE_INIT   = 8,
  parameter int unsigned PULSE_CAP    = 64,
  parameter int unsigned DOUBLINGS    = 4,
  parameter int unsigned MAX_ATTEMPTS = 602
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            init,
  input  logic            advance,
  output logic [PW_W-1:0] width,
  output logic            at_limit
);
  localparam logic [TRY_W-1:0] TRY_LIMIT  = TRY_W'(MAX_ATTEMPTS);
  localparam logic [PW_W-1:0]  FIRST_W    = PW_W'(min_u(PULSE_INIT, PULSE_CAP));
  localparam logic [PW_W-1:0]  CAP_W      = PW_W'(PULSE_CAP);

  logic [TRY_W-1:0] tries;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tries <= '0;
      width <= '0;
    end else if (init) begin
      tries <= TRY_W'(1);
      width <= FIRST_W;
    end else if (advance) begin
      tries <= tries + 1'b1;
      width <= PW_W'(widen_pulse(32'(width), 32'(tries), DOUBLINGS, PULSE_CAP));
    end
  end

  assign at_limit = (tries >= TRY_LIMIT);

  // R4: the pulse width never exceeds its ceiling
  a_r4_width_capped: assert property (@(posedge clk) disable iff (!rst_n)
    width <= CAP_W);
  // R9: no attempt is started past the limit
  a_r9_no_advance_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> !at_limit);
  // R4: width never shrinks within an operation
  a_r4_width_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> width >= $past(width));
endmodule

// File: rtl/erase_addr_walk.sv
module erase_addr_walk #(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic [AW-1:0] first_in,
  input  logic [AW-1:0] last_in,
  input  logic          begin_walk,
  input  logic          step,
  input  logic          clear,
  output logic [AW-1:0] addr,
  output logic          at_last
);
  logic [AW-1:0] first_q;
  logic [AW-1:0] last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= '0;
      last_q  <= '0;
    end else if (arm) begin
      first_q <= first_in;
      last_q  <= last_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          addr <= '0;
    else if (clear)      addr <= '0;
    else if (begin_walk) addr <= first_q;
    else if (step)       addr <= addr + 1'b1;
  end

  assign at_last = (addr == last_q);

  // R6: the walk never steps past the last address
  a_r6_step_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !at_last);
  // R6: the walk always begins at the first address
  a_r6_walk_starts_first: assert property (@(posedge clk) disable iff (!rst_n)
    begin_walk |=> addr == first_q);
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import erase_seq_pkg::*;
#(
  parameter int unsigned BLK_W            = 3,
  parameter int unsigned ADDR_W           = 16,
  parameter int unsigned DATA_W           = 8,
  parameter int unsigned T_ARM_SETTLE     = 1500,
  parameter int unsigned T_PULSE_INIT     = 1250000,
  parameter int unsigned T_PULSE_CAP      = 10000000,
  parameter int unsigned PULSE_DOUBLINGS  = 4,
  parameter int unsigned T_VERIFY_SETTLE  = 800,
  parameter int unsigned T_RELEASE_SETTLE = 400,
  parameter int unsigned MAX_ATTEMPTS     = 602,
  localparam int unsigned NUM_BLK         = 1 << BLK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BLK_W-1:0]  blk_idx,
  input  logic [ADDR_W-1:0] blk_first,
  input  logic [ADDR_W-1:0] blk_last,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [NUM_BLK-1:0] blk_sel,
  output logic              vpp_en,
  output logic              wdog_en,
  output logic              erase_en,
  output logic              verify_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_wr,
  output logic              mem_rd,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam int unsigned PW_W   = $clog2(T_PULSE_CAP + 1);
  localparam int unsigned DLY_MX = max_u(max_u(T_ARM_SETTLE, T_PULSE_CAP),
                                         max_u(T_VERIFY_SETTLE, T_RELEASE_SETTLE));
  localparam int unsigned CW     = $clog2(DLY_MX + 1);
  localparam int unsigned TRY_W  = $clog2(MAX_ATTEMPTS + 1);

  seq_state_t        state;
  logic [BLK_W-1:0]  blk_q;

  // Named internal events
  logic              start_ok;
  logic              dly_last;
  logic              dly_load;
  logic [CW-1:0]     dly_val;
  logic [PW_W-1:0]   pulse_w;
  logic              try_limit;
  logic              walk_last;
  logic              byte_erased;
  logic              byte_pass_last;
  logic              byte_pass_more;
  logic              byte_fail;
  logic              try_again;
  logic              give_up;
  logic              walk_begin;
  logic              walk_clear;

  assign start_ok       = start && (state == ST_IDLE);
  assign byte_erased    = (mem_rdata == '1);
  assign byte_pass_last = (state == ST_READ) && byte_erased && walk_last;
  assign byte_pass_more = (state == ST_READ) && byte_erased && !walk_last;
  assign byte_fail      = (state == ST_READ) && !byte_erased;
  assign try_again      = byte_fail && !try_limit;
  assign give_up        = byte_fail && try_limit;
  assign walk_begin     = (state == ST_VERIFY_SET);
  assign walk_clear     = byte_fail || byte_pass_last;

  // Which wait to arm, chosen by the state that opens it
  always_comb begin
    dly_load = 1'b0;
    dly_val  = '0;
    unique case (state)
      ST_POWER:      begin dly_load = 1'b1; dly_val = CW'(T_ARM_SETTLE); end
      ST_ARM_WAIT:   begin dly_load = dly_last; dly_val = CW'(pulse_w); end
      ST_VERIFY_SET: begin dly_load = 1'b1; dly_val = CW'(T_VERIFY_SETTLE); end
      ST_READ:       begin dly_load = byte_pass_last; dly_val = CW'(T_RELEASE_SETTLE); end
      default:       begin dly_load = 1'b0; dly_val = '0; end
    endcase
  end

  erase_delay_ctr #(.CW(CW)) u_delay (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (dly_load),
    .load_val (dly_val),
    .last     (dly_last)
  );

  erase_attempt_ctl #(
    .TRY_W        (TRY_W),
    .PW_W         (PW_W),
    .PULSE_INIT   (T_PULSE_INIT),
    .PULSE_CAP    (T_PULSE_CAP),
    .DOUBLINGS    (PULSE_DOUBLINGS),
    .MAX_ATTEMPTS (MAX_ATTEMPTS)
  ) u_attempt (
    .clk      (clk),
    .rst_n    (rst_n),
    .init     (start_ok),
    .advance  (try_again),
    .width    (pulse_w),
    .at_limit (try_limit)
  );

  erase_addr_walk #(.AW(ADDR_W)) u_walk (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm        (start_ok),
    .first_in   (blk_first),
    .last_in    (blk_last),
    .begin_walk (walk_begin),
    .step       (byte_pass_more),
    .clear      (walk_clear),
    .addr       (mem_addr),
    .at_last    (walk_last)
  );

  // One-hot selection decoded from the latched index
  logic [NUM_BLK-1:0] sel_onehot;
  for (genvar g = 0; g < NUM_BLK; g++) begin : g_sel
    assign sel_onehot[g] = (blk_q == BLK_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      blk_q     <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      error     <= 1'b0;
      blk_sel   <= '0;
      vpp_en    <= 1'b0;
      wdog_en   <= 1'b0;
      erase_en  <= 1'b0;
      verify_en <= 1'b0;
      mem_wr    <= 1'b0;
      mem_rd    <= 1'b0;
    end else begin
      done  <= 1'b0;
      error <= 1'b0;
      unique case (state)
        ST_IDLE: if (start_ok) begin
          blk_q <= blk_idx;
          busy  <= 1'b1;
          state <= ST_SELECT;
        end
        ST_SELECT: begin
          blk_sel <= sel_onehot;
          state   <= ST_WDOG;
        end
        ST_WDOG: begin
          wdog_en <= 1'b1;
          state   <= ST_POWER;
        end
        ST_POWER: begin
          vpp_en <= 1'b1;
          state  <= ST_ARM_WAIT;
        end
        ST_ARM_WAIT: if (dly_last) begin
          erase_en <= 1'b1;
          state    <= ST_PULSE;
        end
        ST_PULSE: if (dly_last) begin
          erase_en <= 1'b0;
          wdog_en  <= 1'b0;
          state    <= ST_VERIFY_SET;
        end
        ST_VERIFY_SET: begin
          verify_en <= 1'b1;
          state     <= ST_VERIFY_WAIT;
        end
        ST_VERIFY_WAIT: if (dly_last) begin
          mem_wr <= 1'b1;
          state  <= ST_LATCH;
        end
        ST_LATCH: begin
          mem_wr <= 1'b0;
          mem_rd <= 1'b1;
          state  <= ST_READ;
        end
        ST_READ: begin
          mem_rd <= 1'b0;
          if (byte_pass_more) begin
            mem_wr <= 1'b1;
            state  <= ST_LATCH;
          end else if (byte_pass_last) begin
            verify_en <= 1'b0;
            vpp_en    <= 1'b0;
            state     <= ST_RELEASE;
          end else if (try_again) begin
            verify_en <= 1'b0;
            state     <= ST_WDOG;
          end else begin
            verify_en <= 1'b0;
            vpp_en    <= 1'b0;
            blk_sel   <= '0;
            error     <= 1'b1;
            busy      <= 1'b0;
            state     <= ST_IDLE;
          end
        end
        ST_RELEASE: if (dly_last) begin
          blk_sel <= '0;
          done    <= 1'b1;
          busy    <= 1'b0;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_wdata = mem_wr ? '1 : '0;

  // R5: erase and verify modes never overlap
  a_r5_modes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(erase_en && verify_en));
  // R3: an erase pulse runs only under voltage, watchdog and one selected block
  a_r3_pulse_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    erase_en |-> (vpp_en && wdog_en && $onehot(blk_sel)));
  // R3: the watchdog drops together with the pulse
  a_r3_wdog_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(erase_en) |-> !wdog_en);
  // R6: dummy writes only in verify mode and carry the erased value
  a_r6_write_in_verify: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (verify_en && (mem_wdata == '1) && !mem_rd));
  // R6: every read directly follows a latching write
  a_r6_read_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> $past(mem_wr));
  // R10: outcome pulses are exclusive and last one cycle
  a_r10_outcome_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_error_single: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> !error);
  // R8: success leaves nothing powered or selected
  a_r8_done_clean: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (blk_sel == '0 && !vpp_en && !verify_en && !busy));
  // R9: failure leaves nothing powered or selected
  a_r9_error_clean: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (blk_sel == '0 && !vpp_en && !verify_en && !wdog_en && !busy));
  // R1: a start during an operation does not disturb the selection
  a_r1_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && blk_sel != '0) |=> (blk_sel == $past(blk_sel) || blk_sel == '0));
endmodule

// File: tb/flash_erase_seq_test.sv
`timescale 1ns/1ps
module flash_erase_seq_test;
  localparam int BW    = 3;
  localparam int AW    = 8;
  localparam int DW    = 8;
  localparam int NB    = 1 << BW;
  localparam int TZ    = 3;
  localparam int TW    = 2;
  localparam int TCAP  = 20;
  localparam int TDBL  = 4;
  localparam int TVS1  = 2;
  localparam int TVS2  = 3;
  localparam int TMAX  = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [BW-1:0] blk_idx = '0;
  logic [AW-1:0] blk_first = '0;
  logic [AW-1:0] blk_last = '0;
  logic [DW-1:0] mem_rdata;
  logic busy, done, error, vpp_en, wdog_en, erase_en, verify_en, mem_wr, mem_rd;
  logic [NB-1:0] blk_sel;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;

  always #2.5 clk = ~clk;

  flash_erase_seq #(
    .BLK_W(BW), .ADDR_W(AW), .DATA_W(DW), .T_ARM_SETTLE(TZ), .T_PULSE_INIT(TW),
    .T_PULSE_CAP(TCAP), .PULSE_DOUBLINGS(TDBL), .T_VERIFY_SETTLE(TVS1),
    .T_RELEASE_SETTLE(TVS2), .MAX_ATTEMPTS(TMAX)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_idx(blk_idx),
    .blk_first(blk_first), .blk_last(blk_last), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .error(error), .blk_sel(blk_sel), .vpp_en(vpp_en),
    .wdog_en(wdog_en), .erase_en(erase_en), .verify_en(verify_en),
    .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_wdata(mem_wdata)
  );

  // Flash stub: a byte reads erased once enough pulses have been applied
  int need [256];
  int pulses = 0;
  logic e_prev = 1'b0;
  assign mem_rdata = (pulses >= need[mem_addr]) ? 8'hFF : 8'h00;
  always @(negedge clk) begin
    if (e_prev && !erase_en) pulses++;
    e_prev = erase_en;
  end

  typedef struct packed {
    logic busy, done, error;
    logic [NB-1:0] blk;
    logic wdog, vpp, e, ev, wr, rd;
    logic [AW-1:0] addr;
  } snap_t;

  snap_t exp_q[$];
  snap_t cur;
  int checks = 0;
  int fails  = 0;
  int n_done = 0;
  int n_err  = 0;

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic push(int reps);
    for (int i = 0; i < reps; i++) exp_q.push_back(cur);
  endtask

  function automatic int width_of(int k);
    int w = TW;
    int d = (k - 1 < TDBL) ? k - 1 : TDBL;
    for (int i = 0; i < d; i++) w = w * 2;
    return (w > TCAP) ? TCAP : w;
  endfunction

  // Behavioural model: the expected output trace, one entry per clock
  task automatic build_model(int b, int f, int l);
    int a;
    exp_q.delete();
    cur = '0;
    cur.busy = 1'b1; push(1);
    cur.blk = NB'(1) << b; push(1);
    for (int n = 1; n <= TMAX; n++) begin
      cur.wdog = 1'b1; push(1);
      cur.vpp = 1'b1;  push(TZ);
      cur.e = 1'b1;    push(width_of(n));
      cur.e = 1'b0; cur.wdog = 1'b0; push(1);
      a = f;
      cur.ev = 1'b1; cur.addr = AW'(a); push(TVS1);
      forever begin
        cur.wr = 1'b1; push(1);
        cur.wr = 1'b0; cur.rd = 1'b1; push(1);
        cur.rd = 1'b0;
        if (n >= need[a] && a == l) begin
          cur.ev = 1'b0; cur.vpp = 1'b0; cur.addr = '0; push(TVS2);
          cur = '0; cur.done = 1'b1; push(1);
          cur.done = 1'b0; push(2);
          return;
        end else if (n >= need[a]) begin
          a++; cur.addr = AW'(a);
        end else begin
          cur.ev = 1'b0; cur.addr = '0;
          if (n >= TMAX) begin
            cur = '0; cur.error = 1'b1; push(1);
            cur.error = 1'b0; push(2);
            return;
          end
          push(1);
          break;
        end
      end
    end
  endtask

  task automatic compare(snap_t x);
    chk(busy == x.busy, "R1", "busy", int'(busy), int'(x.busy));
    chk(blk_sel == x.blk, "R2", "blk_sel", int'(blk_sel), int'(x.blk));
    chk(wdog_en == x.wdog, "R3", "wdog_en", int'(wdog_en), int'(x.wdog));
    chk(erase_en == x.e, "R4", "erase_en", int'(erase_en), int'(x.e));
    chk(verify_en == x.ev, "R5", "verify_en", int'(verify_en), int'(x.ev));
    chk(vpp_en == x.vpp, "R8", "vpp_en", int'(vpp_en), int'(x.vpp));
    chk(mem_wr == x.wr && mem_rd == x.rd, "R6", "wr/rd",
        int'({mem_wr, mem_rd}), int'({x.wr, x.rd}));
    chk(mem_addr == x.addr, "R6", "mem_addr", int'(mem_addr), int'(x.addr));
    if (mem_wr) chk(mem_wdata == 8'hFF, "R6", "mem_wdata", int'(mem_wdata), 255);
    chk(done == x.done, "R10", "done", int'(done), int'(x.done));
    chk(error == x.error, "R9", "error", int'(error), int'(x.error));
    if (done) n_done++;
    if (error) n_err++;
  endtask

  task automatic run_op(int b, int f, int l, bit poke, bit expect_ok);
    int idx = 0;
    build_model(b, f, l);
    n_done = 0; n_err = 0;
    @(negedge clk);
    pulses = 0;
    start = 1'b1; blk_idx = BW'(b); blk_first = AW'(f); blk_last = AW'(l);
    while (exp_q.size() > 0) begin
      @(negedge clk);
      start = 1'b0;
      compare(exp_q.pop_front());
      idx++;
      // R1: a start pulse while busy must be ignored
      if (poke && (idx == 4 || idx == 9)) begin
        start = 1'b1; blk_idx = BW'(b ^ 1); blk_first = 8'hF0; blk_last = 8'hF0;
      end
    end
    // R10: exactly one outcome per started operation
    chk(n_done == (expect_ok ? 1 : 0) && n_err == (expect_ok ? 0 : 1), "R10",
        "done/error count", n_done * 10 + n_err, expect_ok ? 10 : 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL R10 watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) need[i] = 1;
    repeat (3) @(negedge clk);
    // R11: outputs low in reset
    chk({busy, done, error, vpp_en, wdog_en, erase_en, verify_en, mem_wr, mem_rd} == '0
        && blk_sel == '0 && mem_addr == '0, "R11", "reset outputs", int'(blk_sel), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, error, vpp_en, erase_en, verify_en} == '0 && blk_sel == '0,
        "R11", "after reset", int'(busy), 0);

    // Clean block, one attempt, with starts while busy (R1, R2, R8)
    run_op(2, 8'h10, 8'h13, 1'b1, 1'b1);
    chk(pulses == 1, "R7", "pulses clean block", pulses, 1);

    // One stubborn byte mid-block: retry and restart the walk (R7, R4)
    need[8'h23] = 3;
    run_op(5, 8'h20, 8'h25, 1'b0, 1'b1);
    chk(pulses == 3, "R7", "pulses with retries", pulses, 3);

    // Width doubles, then clamps to the ceiling (R4)
    need[8'h31] = 6;
    run_op(0, 8'h30, 8'h31, 1'b1, 1'b1);
    chk(pulses == 6, "R4", "pulses to ceiling", pulses, 6);

    // Never erases: error after the attempt limit (R9)
    need[8'h40] = 99;
    run_op(7, 8'h40, 8'h40, 1'b0, 1'b0);
    chk(pulses == TMAX, "R9", "pulses before error", pulses, TMAX);

    // Single-byte block right after an error (R2, R8)
    run_op(3, 8'h50, 8'h50, 1'b0, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule